// File: doc/BRIEF.md
# Processor Status Word Register with Masked Write

This block holds the 32-bit status word of a processor core. The top four bits carry the condition flags (negative, zero, carry, overflow). A five-bit processor-mode field sits at the bottom of the word, and the remaining bits are general control bits. The whole word is always visible on a read port.

Software changes the word with a value plus a per-bit mask. Only masked bits of the control part change. If the mask touches any flag bit, all four flags are reloaded together from the value. An ALU has its own port that loads the four flags directly. A masked write that covers the flags wins over an ALU update in the same cycle.

When a write changes any bit of the mode field, the block emits a one-cycle switch pulse in the following cycle, together with the resulting mode. Logic elsewhere uses this pulse to swap banked state.

Top module: `status_word`

## Requirements
- R1: After reset the read word is 32'h0000_0013: all flags clear, all control bits clear, mode field (bits 4..0) equal to 5'b10011. `modeSwitch` is low.
- R2: On a write (`wrEn` high) whose mask has any of bits 31..28 set, all four flags (N bit 31, Z bit 30, C bit 29, V bit 28) take `wrData[31:28]` at the next clock, whichever of those mask bits are set.
- R3: On a write, each bit i in 27..0 becomes `wrData[i]` where `wrMask[i]` is 1 and keeps its old value where `wrMask[i]` is 0.
- R4: When `aluEn` is high and no flag-covering write occurs, the flags take `aluFlags` at the next clock, with `aluFlags[3]`=N, `[2]`=Z, `[1]`=C, `[0]`=V. This includes a write whose mask leaves bits 31..28 clear.
- R5: When a flag-covering write and `aluEn` occur in the same cycle, the flags come from the write and `aluFlags` is ignored.
- R6: When a write has a masked bit in 4..0 whose value differs from the current word, `modeSwitch` is high for the next cycle and `modeNew` then equals the new mode field (bits 4..0 of the read word).
- R7: `modeSwitch` stays low after a write whose masked mode bits all equal the current ones, after a write that masks no mode bit, and in any cycle that follows one with no write.
- R8: With `wrEn` and `aluEn` both low the read word holds its value.
- R9: A write with an all-zero mask and `aluEn` low leaves the whole word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Masked write strobe |
| wrData | input | 32 | Write value |
| wrMask | input | 32 | Per-bit write enable |
| aluEn | input | 1 | ALU flag load strobe |
| aluFlags | input | 4 | New flags {N,Z,C,V} |
| rdData | output | 32 | Current status word |
| modeSwitch | output | 1 | One-cycle mode change event |
| modeNew | output | 5 | Mode value that goes with the event |

## Verification
On every cycle the assertions check the flag source rules (a write beats the ALU only when its mask covers the flags), the bitwise merge of the control bits, holding when idle, and the link between a differing masked mode bit and the next cycle's pulse with its mode value. The bench adds the scenarios that a property cannot pick out: the exact reset word, a write with a single flag mask bit that still reloads all four flags, partial mode masks that change only some mode bits, and a long run of mixed writes and ALU updates compared against a behavioural model.

// File: rtl/status_word_pkg.sv
package status_word_pkg;
  localparam int FLAG_COUNT = 4;

  typedef struct packed {
    logic flagFromWrite;
    logic flagFromAlu;
    logic mergeEn;
    logic modeChange;
  } strobeT;
endpackage

// File: rtl/status_word_ctrl.sv
module status_word_ctrl
  import status_word_pkg::*;
#(
  parameter int MODE_W = 5
) (
  input  logic                  wrEn,
  input  logic [FLAG_COUNT-1:0] wrFlagMask,
  input  logic                  aluEn,
  input  logic [MODE_W-1:0]     curMode,
  input  logic [MODE_W-1:0]     wrModeVal,
  input  logic [MODE_W-1:0]     wrModeMask,
  output strobeT                stb
);
  logic [MODE_W-1:0] modeDiff;
  logic              flagHit;

  always_comb begin
    modeDiff = (curMode ^ wrModeVal) & wrModeMask;
    flagHit  = wrEn && (|wrFlagMask);
    stb.flagFromWrite = flagHit;
    stb.flagFromAlu   = aluEn && !flagHit;
    stb.mergeEn       = wrEn;
    stb.modeChange    = wrEn && (|modeDiff);
  end
endmodule

// File: rtl/status_word_dp.sv
module status_word_dp
  import status_word_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              MODE_W     = 5,
  parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                stb,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [DATA_W-FLAG_COUNT-1:0] restMask,
  input  logic [FLAG_COUNT-1:0] aluFlags,
  output logic [DATA_W-1:0]     word,
  output logic                  modeSwitch,
  output logic [MODE_W-1:0]     modeNew
);
  localparam int REST_W = DATA_W - FLAG_COUNT;

  logic [FLAG_COUNT-1:0] flagQ;
  logic [REST_W-1:0]     restQ;
  logic [REST_W-1:0]     restNext;
  logic                  pulseQ;
  logic [MODE_W-1:0]     modeQ;

  for (genvar b = 0; b < REST_W; b++) begin : g_merge
    assign restNext[b] = (stb.mergeEn && restMask[b]) ? wrData[b] : restQ[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ  <= '0;
      restQ  <= {{(REST_W-MODE_W){1'b0}}, RESET_MODE};
      pulseQ <= 1'b0;
      modeQ  <= RESET_MODE;
    end else begin
      if (stb.flagFromWrite) begin
        flagQ <= wrData[DATA_W-1 -: FLAG_COUNT];
      end else if (stb.flagFromAlu) begin
        flagQ <= aluFlags;
      end
      restQ  <= restNext;
      pulseQ <= stb.modeChange;
      if (stb.modeChange) begin
        modeQ <= restNext[MODE_W-1:0];
      end
    end
  end

  assign word       = {flagQ, restQ};
  assign modeSwitch = pulseQ;
  assign modeNew    = modeQ;
endmodule

// File: rtl/status_word.sv
module status_word
  import status_word_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                MODE_W     = 5,
  parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [DATA_W-1:0]     wrMask,
  input  logic                  aluEn,
  input  logic [FLAG_COUNT-1:0] aluFlags,
  output logic [DATA_W-1:0]     rdData,
  output logic                  modeSwitch,
  output logic [MODE_W-1:0]     modeNew
);
  localparam int REST_W = DATA_W - FLAG_COUNT;

  strobeT            stb;
  logic [DATA_W-1:0] word;

  status_word_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .wrEn       (wrEn),
    .wrFlagMask (wrMask[DATA_W-1 -: FLAG_COUNT]),
    .aluEn      (aluEn),
    .curMode    (word[MODE_W-1:0]),
    .wrModeVal  (wrData[MODE_W-1:0]),
    .wrModeMask (wrMask[MODE_W-1:0]),
    .stb        (stb)
  );

  status_word_dp #(
    .DATA_W     (DATA_W),
    .MODE_W     (MODE_W),
    .RESET_MODE (RESET_MODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .restMask   (wrMask[REST_W-1:0]),
    .aluFlags   (aluFlags),
    .word       (word),
    .modeSwitch (modeSwitch),
    .modeNew    (modeNew)
  );

  assign rdData = word;
endmodule

// File: rtl/status_word_chk.sv
module status_word_chk #(
  parameter int DATA_W = 32,
  parameter int MODE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] wrMask,
  input logic              aluEn,
  input logic [3:0]        aluFlags,
  input logic [DATA_W-1:0] rdData,
  input logic              modeSwitch,
  input logic [MODE_W-1:0] modeNew
);
  localparam int REST_W = DATA_W - 4;

  logic flagWrite;
  logic modeDiffers;
  assign flagWrite   = wrEn && (|wrMask[DATA_W-1 -: 4]);
  assign modeDiffers = |((rdData[MODE_W-1:0] ^ wrData[MODE_W-1:0]) & wrMask[MODE_W-1:0]);

  a_r2_flags_from_write: assert property (@(posedge clk) disable iff (!rstN)
    flagWrite |=> rdData[DATA_W-1 -: 4] == $past(wrData[DATA_W-1 -: 4]));

  a_r3_bit_merge: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[REST_W-1:0] ==
      (($past(rdData[REST_W-1:0]) & ~$past(wrMask[REST_W-1:0])) |
       ($past(wrData[REST_W-1:0]) & $past(wrMask[REST_W-1:0]))));

  a_r4_alu_flags: assert property (@(posedge clk) disable iff (!rstN)
    (aluEn && !flagWrite) |=> rdData[DATA_W-1 -: 4] == $past(aluFlags));

  a_r6_switch_on_change: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && modeDiffers) |=> modeSwitch);

  a_r6_mode_value: assert property (@(posedge clk) disable iff (!rstN)
    modeSwitch |-> modeNew == rdData[MODE_W-1:0]);

  a_r7_no_spurious_switch: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && modeDiffers) |=> !modeSwitch);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !aluEn) |=> $stable(rdData));
endmodule

bind status_word status_word_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .wrMask     (wrMask),
  .aluEn      (aluEn),
  .aluFlags   (aluFlags),
  .rdData     (rdData),
  .modeSwitch (modeSwitch),
  .modeNew    (modeNew)
);

// File: tb/status_word_bench.sv
`timescale 1ns/1ps
module status_word_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] wrMask = '0;
  logic        aluEn = 1'b0;
  logic [3:0]  aluFlags = '0;
  logic [31:0] rdData;
  logic        modeSwitch;
  logic [4:0]  modeNew;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  logic [31:0] refWord;
  logic        refPulse;
  logic [4:0]  refMode;

  always #10 clk = ~clk;

  status_word u_status_word (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrMask(wrMask),
    .aluEn(aluEn), .aluFlags(aluFlags), .rdData(rdData),
    .modeSwitch(modeSwitch), .modeNew(modeNew)
  );

  always @(posedge clk) begin
    logic [31:0] nxt;
    bit changed;
    if (!rstN) begin
      refWord  <= 32'h0000_0013;
      refPulse <= 1'b0;
      refMode  <= 5'b10011;
    end else begin
      nxt = refWord;
      changed = 0;
      if (wrEn && wrMask[31:28] != 4'b0) nxt[31:28] = wrData[31:28];
      else if (aluEn) nxt[31:28] = aluFlags;
      if (wrEn) begin
        for (int i = 0; i < 28; i++) begin
          if (wrMask[i]) begin
            if (i < 5 && refWord[i] != wrData[i]) changed = 1;
            nxt[i] = wrData[i];
          end
        end
      end
      refWord  <= nxt;
      refPulse <= changed;
      if (changed) refMode <= nxt[4:0];
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (rdData !== refWord) begin
      errors++;
      $display("FAIL %s word actual=%h expected=%h", tag, rdData, refWord);
    end
    checks++;
    if (modeSwitch !== refPulse || (refPulse && modeNew !== refMode)) begin
      errors++;
      $display("FAIL %s switch actual=%b/%h expected=%b/%h",
               tag, modeSwitch, modeNew, refPulse, refMode);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [31:0] d,
                      input logic [31:0] m, input logic ae, input logic [3:0] f);
    wrEn = we; wrData = d; wrMask = m; aluEn = ae; aluFlags = f;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic expectWord(input string tag, input logic [31:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s fixed actual=%h expected=%h", tag, rdData, exp);
    end
  endtask

  task automatic expectPulse(input string tag, input logic p, input logic [4:0] md);
    checks++;
    if (modeSwitch !== p || (p && modeNew !== md)) begin
      errors++;
      $display("FAIL %s pulse actual=%b/%h expected=%b/%h", tag, modeSwitch, modeNew, p, md);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectWord("R1", 32'h0000_0013);
    expectPulse("R1", 1'b0, 5'b0);
    compare("R1");
    // R8 idle hold
    step("R8", 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 4'hF);
    step("R8", 0, 32'h0, 32'h0, 0, 4'h0);
    // R4 ALU load
    step("R4", 0, 32'h0, 32'h0, 1, 4'b1010);
    expectWord("R4", 32'hA000_0013);
    // R2 one flag mask bit reloads all four
    step("R2", 1, 32'h5000_0000, 32'h8000_0000, 0, 4'h0);
    expectWord("R2", 32'h5000_0013);
    // R3 merge of control bits
    step("R3", 1, 32'h0ABC_DEF3, 32'h00FF_0F00, 0, 4'h0);
    expectWord("R3", 32'h50BC_0E13);
    // R5 write wins over ALU
    step("R5", 1, 32'h3000_0000, 32'h1000_0000, 1, 4'hC);
    expectWord("R5", 32'h30BC_0E13);
    // R4 write without flag mask lets ALU through
    step("R4", 1, 32'h0000_1000, 32'h0000_F000, 1, 4'h9);
    expectWord("R4", 32'h90BC_1E13);
    // R6 full mode change then R7 pulse drops
    step("R6", 1, 32'h0000_001F, 32'h0000_001F, 0, 4'h0);
    expectPulse("R6", 1'b1, 5'h1F);
    step("R7", 0, 32'h0, 32'h0, 0, 4'h0);
    expectPulse("R7", 1'b0, 5'h0);
    // R7 same mode rewritten, and mode change masked off
    step("R7", 1, 32'h0000_001F, 32'h0000_001F, 0, 4'h0);
    expectPulse("R7", 1'b0, 5'h0);
    step("R7", 1, 32'h0000_0000, 32'h0000_FF00, 0, 4'h0);
    expectPulse("R7", 1'b0, 5'h0);
    // R6 partial mode mask
    step("R6", 1, 32'h0000_0000, 32'h0000_0001, 0, 4'h0);
    expectPulse("R6", 1'b1, 5'h1E);
    expectWord("R6", 32'h90BC_001E);
    // R9 zero mask write
    step("R9", 1, 32'hFFFF_FFFF, 32'h0000_0000, 0, 4'h0);
    expectWord("R9", 32'h90BC_001E);
    // mixed traffic against the model (R2 R3 R4 R5 R6 R7 R8)
    for (int n = 0; n < 400; n++) begin
      step("R3", 1'($urandom_range(0, 1)), $urandom(),
           ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom(),
           1'($urandom_range(0, 1)), 4'($urandom()));
    end
    step("R8", 0, 32'h0, 32'h0, 0, 4'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule